// File: doc/BRIEF.md
# Packet-Command PIO Read Sequencer

This block is the device side of a packet command on an 8-register, ATA-style host interface. A host loads a byte count limit, issues the packet command, and then writes a 12-byte command packet as six 16-bit words on the data port. The sequencer decodes a read-blocks request from that packet. It then returns the requested blocks as 16-bit word reads on the data port, split into bursts. Each burst is capped by the host limit, with bit 0 of the limit cleared.

Before each burst the block raises its interrupt line and shows data-request in the status byte. The burst size can be read back on the two byte-count registers. A final interrupt marks completion. Block data comes from an internal pattern generator by default. A parameter selects a memory read port instead. Out-of-range limits, a DMA request and unknown packet opcodes abort the command with the error bit set.

Top module: `pktpio_engine`

## Requirements
- R1: After reset the status byte (register 7) reads 0x40 (ready only), `intrq` is low and a data-port read (register 0) returns 0.
- R2: Writing 0xA0 to register 7 while idle, with a valid limit and feature bit 0 clear, shows status 0xC0 (busy) for exactly one cycle. Status then reads 0x48 (data-request plus ready) until six data-port word writes are taken. A status byte never has busy (bit 7) and data-request (bit 3) both set.
- R3: The limit is register 4 (low byte) and register 5 (high byte), latched when the command is issued. If the limit with bit 0 cleared is zero, or the limit is 0xFFFF, or feature bit 0 is set, the command aborts at once: status 0x41 (error bit 0) and `intrq` high.
- R4: Packet word i carries packet byte 2i in bits 7:0 and byte 2i+1 in bits 15:8. Byte 0 is the opcode, bytes 2..5 are the start block (most significant first) and bytes 7..8 are the block count (most significant first). An opcode other than 0x28 aborts with status 0x41 and `intrq` high.
- R5: Each burst holds min(limit with bit 0 cleared, remaining bytes) bytes, with 2048 bytes per block. Before each burst, `intrq` rises, status reads 0x48, and registers 4/5 read the burst byte count.
- R6: Data words in the default pattern mode are {block[7:0], w[7:0]}, where block is the absolute block number and w is the word index (0..1023) inside that block. Words arrive in ascending order.
- R7: After the last word of the last burst, `intrq` rises and status reads 0x40. A block count of zero completes the same way with no burst.
- R8: A read of register 7 clears a pending interrupt.
- R9: Data-port writes while data-request is clear are ignored. Data-port reads outside a burst return 0 and advance nothing.
- R10: Between two bursts the status reads 0xC0 for one cycle, with `intrq` low, before the next burst's interrupt.
- R11: `mem_addr` shows the low MEM_AW bits of block*1024 + w for the word currently offered on the data port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register select |
| bus_wr | input | 1 | Register write strobe, one cycle per access |
| bus_rd | input | 1 | Register read strobe; side effects take place at the clock edge |
| bus_wdata | input | 16 | Write data (byte registers use bits 7:0) |
| bus_rdata | output | 16 | Read data for the selected register, combinational |
| intrq | output | 1 | Interrupt request to the host |
| mem_addr | output | MEM_AW | Word address of the current data word |
| mem_rdata | input | 16 | Word from an external array, used when USE_MEM is set |

## Verification
Transfers are run over a table of limits and lengths. A limit above the total length gives a single burst, and an exact multiple of the limit gives equal bursts. An odd limit shows the bit-0 clearing, and a limit of 2 gives one-word bursts. The smallest and largest legal limits split the data at opposite extremes. A start block of 0x1FF shows the carry from the word index into the block number. A zero block count gives the no-burst completion. Directed cases cover each abort cause separately and stray data-port traffic before a command, which would shift every packet byte if it were counted.

// File: rtl/pktpio_pkg.sv
package pktpio_pkg;
  // status byte bit positions
  localparam int SB_BSY  = 7;
  localparam int SB_DRDY = 6;
  localparam int SB_DRQ  = 3;
  localparam int SB_ERR  = 0;

  // register select codes
  localparam logic [2:0] RA_DATA = 3'd0;
  localparam logic [2:0] RA_FEAT = 3'd1;
  localparam logic [2:0] RA_CNT  = 3'd2;
  localparam logic [2:0] RA_LBA0 = 3'd3;
  localparam logic [2:0] RA_BCL  = 3'd4;
  localparam logic [2:0] RA_BCH  = 3'd5;
  localparam logic [2:0] RA_DEV  = 3'd6;
  localparam logic [2:0] RA_CMD  = 3'd7;

  localparam logic [7:0] OPC_PACKET = 8'hA0;
  localparam logic [7:0] OPC_RDBLK  = 8'h28;

  localparam int PKT_WORDS = 6;
  localparam int PKT_CW    = $clog2(PKT_WORDS + 1);

  typedef enum logic [2:0] {
    S_IDLE,
    S_ACC,
    S_PKT,
    S_PARSE,
    S_XFER,
    S_NEXT
  } seq_t;
endpackage

// File: rtl/pktpio_pkt_decode.sv
module pktpio_pkt_decode
  import pktpio_pkg::*;
(
  input  logic [PKT_WORDS*16-1:0] pkt_flat,
  output logic [7:0]              opcode,
  output logic [31:0]             lba,
  output logic [15:0]             nblk
);
  localparam int NBYTES = PKT_WORDS * 2;

  logic [7:0] pb [NBYTES];

  // byte k sits at flat bits 8k+7..8k (low byte of each word first)
  for (genvar k = 0; k < NBYTES; k++) begin : g_bytes
    assign pb[k] = pkt_flat[8*k +: 8];
  end

  assign opcode = pb[0];
  assign lba    = {pb[2], pb[3], pb[4], pb[5]};
  assign nblk   = {pb[7], pb[8]};

  logic unused_bytes;
  assign unused_bytes = ^{pb[1], pb[6], pb[9], pb[10], pb[11]};
endmodule

// File: rtl/pktpio_burst.sv
module pktpio_burst #(
  parameter int REM_W = 26
) (
  input  logic [15:0]      limit,
  input  logic [REM_W-1:0] rem_words,
  output logic [14:0]      burst_words,
  output logic             lim_ok
);
  logic [14:0] lim_half;

  assign lim_half = limit[15:1];
  assign lim_ok   = (lim_half != 15'd0) && (limit != 16'hFFFF);

  always_comb begin
    if (rem_words < REM_W'(lim_half)) burst_words = rem_words[14:0];
    else                              burst_words = lim_half;
  end
endmodule

// File: rtl/pktpio_src.sv
module pktpio_src #(
  parameter bit USE_MEM  = 1'b0,
  parameter int BLK_LOG2 = 10,
  parameter int MEM_AW   = 16
) (
  input  logic [31:0]         blk,
  input  logic [BLK_LOG2-1:0] widx,
  input  logic [15:0]         mem_rdata,
  output logic [15:0]         word,
  output logic [MEM_AW-1:0]   mem_addr
);
  logic [31+BLK_LOG2:0] full_addr;

  assign full_addr = {blk, widx};
  assign mem_addr  = full_addr[MEM_AW-1:0];

  if (USE_MEM) begin : g_mem
    assign word = mem_rdata;
    logic unused_mem;
    assign unused_mem = ^full_addr;
  end else begin : g_pat
    logic [31:0] wext;
    assign wext = 32'(widx);
    assign word = {blk[7:0], wext[7:0]};
    logic unused_pat;
    assign unused_pat = ^{mem_rdata, full_addr, wext};
  end
endmodule

// File: rtl/pktpio_engine.sv
module pktpio_engine
  import pktpio_pkg::*;
#(
  parameter bit USE_MEM  = 1'b0,
  parameter int BLK_LOG2 = 10,
  parameter int MEM_AW   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              intrq,
  output logic [MEM_AW-1:0] mem_addr,
  input  logic [15:0]       mem_rdata
);
  localparam int REM_W = 16 + BLK_LOG2;

  seq_t st_q, st_d;

  logic [7:0] feat_q, cnt_q, lba0_q, bcl_q, bch_q, dev_q;
  logic [15:0] lim_q, lim_d, lim_in;
  logic [PKT_CW-1:0] pcnt_q, pcnt_d;
  logic [15:0] pkt_q [PKT_WORDS];
  logic [PKT_WORDS*16-1:0] pkt_flat;
  logic err_q, err_d, irq_q, irq_d, irq_set;
  logic [31:0] blk_q, blk_d;
  logic [BLK_LOG2-1:0] widx_q, widx_d;
  logic [REM_W-1:0] rem_q, rem_d, rem_sel, nblk_words;
  logic [14:0] bleft_q, bleft_d, burst_words;
  logic [15:0] bbytes_q, bbytes_d;
  logic lim_ok;

  logic [7:0] dec_op;
  logic [31:0] dec_lba;
  logic [15:0] dec_nblk;
  logic [15:0] src_word;

  // ---- host access decode ----
  logic cmd_wr, dwr, drd, srd, idle_wr;
  assign idle_wr = bus_wr && (st_q == S_IDLE);
  assign cmd_wr  = idle_wr && (bus_addr == RA_CMD) && (bus_wdata[7:0] == OPC_PACKET);
  assign dwr     = bus_wr && (bus_addr == RA_DATA) && (st_q == S_PKT);
  assign drd     = bus_rd && (bus_addr == RA_DATA) && (st_q == S_XFER);
  assign srd     = bus_rd && (bus_addr == RA_CMD);

  // ---- packet storage, one enabled register per word ----
  for (genvar i = 0; i < PKT_WORDS; i++) begin : g_pkt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               pkt_q[i] <= '0;
      else if (dwr && (pcnt_q == PKT_CW'(i)))   pkt_q[i] <= bus_wdata;
    end
    assign pkt_flat[16*i +: 16] = pkt_q[i];
  end

  pktpio_pkt_decode u_dec (
    .pkt_flat (pkt_flat),
    .opcode   (dec_op),
    .lba      (dec_lba),
    .nblk     (dec_nblk)
  );

  assign nblk_words = {dec_nblk, {BLK_LOG2{1'b0}}};
  assign rem_sel    = (st_q == S_PARSE) ? nblk_words : rem_q;
  assign lim_in     = (st_q == S_IDLE) ? {bch_q, bcl_q} : lim_q;

  pktpio_burst #(.REM_W(REM_W)) u_burst (
    .limit       (lim_in),
    .rem_words   (rem_sel),
    .burst_words (burst_words),
    .lim_ok      (lim_ok)
  );

  pktpio_src #(.USE_MEM(USE_MEM), .BLK_LOG2(BLK_LOG2), .MEM_AW(MEM_AW)) u_src (
    .blk       (blk_q),
    .widx      (widx_q),
    .mem_rdata (mem_rdata),
    .word      (src_word),
    .mem_addr  (mem_addr)
  );

  // ---- byte registers, writable while idle ----
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      feat_q <= '0; cnt_q <= '0; lba0_q <= '0;
      bcl_q  <= '0; bch_q <= '0; dev_q  <= '0;
    end else if (idle_wr) begin
      case (bus_addr)
        RA_FEAT: feat_q <= bus_wdata[7:0];
        RA_CNT:  cnt_q  <= bus_wdata[7:0];
        RA_LBA0: lba0_q <= bus_wdata[7:0];
        RA_BCL:  bcl_q  <= bus_wdata[7:0];
        RA_BCH:  bch_q  <= bus_wdata[7:0];
        RA_DEV:  dev_q  <= bus_wdata[7:0];
        default: ;
      endcase
    end
  end

  // ---- sequencer next state ----
  always_comb begin
    st_d     = st_q;
    pcnt_d   = pcnt_q;
    lim_d    = lim_q;
    err_d    = err_q;
    blk_d    = blk_q;
    widx_d   = widx_q;
    rem_d    = rem_q;
    bleft_d  = bleft_q;
    bbytes_d = bbytes_q;
    irq_set  = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (cmd_wr) begin
          if (feat_q[0] || !lim_ok) begin
            err_d   = 1'b1;
            irq_set = 1'b1;
          end else begin
            st_d   = S_ACC;
            err_d  = 1'b0;
            lim_d  = lim_in;
            pcnt_d = '0;
          end
        end
      end
      S_ACC: st_d = S_PKT;
      S_PKT: begin
        if (dwr) begin
          pcnt_d = pcnt_q + PKT_CW'(1);
          if (pcnt_q == PKT_CW'(PKT_WORDS - 1)) st_d = S_PARSE;
        end
      end
      S_PARSE: begin
        if (dec_op != OPC_RDBLK) begin
          st_d    = S_IDLE;
          err_d   = 1'b1;
          irq_set = 1'b1;
        end else if (dec_nblk == 16'd0) begin
          st_d    = S_IDLE;
          irq_set = 1'b1;
        end else begin
          st_d     = S_XFER;
          blk_d    = dec_lba;
          widx_d   = '0;
          rem_d    = nblk_words;
          bleft_d  = burst_words;
          bbytes_d = {burst_words, 1'b0};
          irq_set  = 1'b1;
        end
      end
      S_XFER: begin
        if (drd) begin
          rem_d   = rem_q - REM_W'(1);
          bleft_d = bleft_q - 15'd1;
          widx_d  = widx_q + BLK_LOG2'(1);
          if (&widx_q) blk_d = blk_q + 32'd1;
          if (bleft_q == 15'd1) begin
            if (rem_q == REM_W'(1)) begin
              st_d    = S_IDLE;
              irq_set = 1'b1;
            end else begin
              st_d = S_NEXT;
            end
          end
        end
      end
      S_NEXT: begin
        st_d     = S_XFER;
        bleft_d  = burst_words;
        bbytes_d = {burst_words, 1'b0};
        irq_set  = 1'b1;
      end
      default: st_d = S_IDLE;
    endcase
    irq_d = irq_set ? 1'b1 : (srd ? 1'b0 : irq_q);
  end

  // ---- sequencer registers ----
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      pcnt_q   <= '0;
      lim_q    <= '0;
      err_q    <= 1'b0;
      irq_q    <= 1'b0;
      blk_q    <= '0;
      widx_q   <= '0;
      rem_q    <= '0;
      bleft_q  <= '0;
      bbytes_q <= '0;
    end else begin
      st_q     <= st_d;
      pcnt_q   <= pcnt_d;
      lim_q    <= lim_d;
      err_q    <= err_d;
      irq_q    <= irq_d;
      blk_q    <= blk_d;
      widx_q   <= widx_d;
      rem_q    <= rem_d;
      bleft_q  <= bleft_d;
      bbytes_q <= bbytes_d;
    end
  end

  assign intrq = irq_q;

  // ---- status and read mux ----
  logic bsy, drq;
  logic [7:0] stat_b;
  assign bsy = (st_q == S_ACC) || (st_q == S_PARSE) || (st_q == S_NEXT);
  assign drq = (st_q == S_PKT) || (st_q == S_XFER);

  always_comb begin
    stat_b          = '0;
    stat_b[SB_BSY]  = bsy;
    stat_b[SB_DRDY] = 1'b1;
    stat_b[SB_DRQ]  = drq;
    stat_b[SB_ERR]  = err_q;
  end

  logic in_burst;
  assign in_burst = (st_q == S_XFER) || (st_q == S_NEXT);

  always_comb begin
    case (bus_addr)
      RA_DATA: bus_rdata = (st_q == S_XFER) ? src_word : 16'd0;
      RA_FEAT: bus_rdata = {8'd0, feat_q};
      RA_CNT:  bus_rdata = {8'd0, cnt_q};
      RA_LBA0: bus_rdata = {8'd0, lba0_q};
      RA_BCL:  bus_rdata = {8'd0, in_burst ? bbytes_q[7:0]  : bcl_q};
      RA_BCH:  bus_rdata = {8'd0, in_burst ? bbytes_q[15:8] : bch_q};
      RA_DEV:  bus_rdata = {8'd0, dev_q};
      default: bus_rdata = {8'd0, stat_b};
    endcase
  end

  // ---- assertions ----
  p_bsy_drq_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat_b[SB_BSY] && stat_b[SB_DRQ]));

  p_pkt_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_PKT) |-> (pcnt_q < PKT_CW'(PKT_WORDS)));

  p_burst_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_XFER) |-> ((bleft_q != 15'd0) && (bleft_q <= lim_q[15:1])));

  p_last_word_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (drd && (bleft_q == 15'd1) && (rem_q == REM_W'(1))) |=> (intrq && (st_q == S_IDLE)));

  p_status_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (srd && !irq_set) |=> !intrq);

  p_stray_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == RA_DATA) && (st_q != S_PKT)) |=> $stable(pcnt_q));

  p_hold_word_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == S_XFER) && !drd) |=> ((st_q == S_XFER) && $stable(mem_addr)));
endmodule

// File: tb/sim_pktpio_engine.sv
module sim_pktpio_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        intrq;
  logic [15:0] mem_addr;
  logic [15:0] mem_rdata = '0;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  pktpio_engine u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .intrq(intrq), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  // {limit, start block, block count, expected bursts}
  localparam logic [79:0] VEC [7] = '{
    {16'd5120,  32'h0000_0000, 16'd1,  16'd1},
    {16'd5120,  32'h0000_0000, 16'd10, 16'd4},
    {16'd5121,  32'h0000_0007, 16'd3,  16'd2},
    {16'd2,     32'h0000_0003, 16'd1,  16'd1024},
    {16'd3000,  32'h0000_01FF, 16'd2,  16'd2},
    {16'hFFFE,  32'h1234_5678, 16'd33, 16'd2},
    {16'd100,   32'h0000_0005, 16'd0,  16'd0}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_irq(input string req);
    int n = 0;
    while (!intrq && n < 64) begin
      @(negedge clk);
      n++;
    end
    check(intrq === 1'b1, req, "interrupt did not rise", 32'(intrq), 32'd1);
  endtask

  task automatic send_packet(input logic [7:0] opc, input logic [31:0] lba,
                             input logic [15:0] nblk);
    logic [7:0] b [12];
    for (int k = 0; k < 12; k++) b[k] = 8'd0;
    b[0] = opc;
    b[2] = lba[31:24]; b[3] = lba[23:16]; b[4] = lba[15:8]; b[5] = lba[7:0];
    b[7] = nblk[15:8]; b[8] = nblk[7:0];
    for (int i = 0; i < 6; i++) bus_write(3'd0, {b[2*i+1], b[2*i]});
  endtask

  task automatic issue(input logic [15:0] lim, input logic [7:0] feat);
    bus_write(3'd4, {8'd0, lim[7:0]});
    bus_write(3'd5, {8'd0, lim[15:8]});
    bus_write(3'd1, {8'd0, feat});
    bus_write(3'd7, 16'h00A0);
  endtask

  task automatic run_xfer(input logic [15:0] lim, input logic [31:0] lba,
                          input logic [15:0] nblk, input int exp_b);
    logic [15:0] d, lo, hi;
    int remaining, bursts, idx, cnt, exp_cnt, mism;
    logic [31:0] first_act, first_exp;
    logic [31:0] blk;
    logic [9:0] w;
    issue(lim, 8'd0);
    peek(3'd7, d);
    check(d == 16'h00C0, "R2", "busy after command", 32'(d), 32'h00C0);
    @(negedge clk);
    peek(3'd7, d);
    check(d == 16'h0048, "R2", "packet request", 32'(d), 32'h0048);
    send_packet(8'h28, lba, nblk);
    remaining = int'(nblk) * 2048;
    bursts = 0;
    idx = 0;
    while (remaining > 0) begin
      wait_irq("R5");
      peek(3'd4, lo);
      peek(3'd5, hi);
      cnt = int'({hi[7:0], lo[7:0]});
      exp_cnt = (int'(lim & 16'hFFFE) < remaining) ? int'(lim & 16'hFFFE) : remaining;
      check(cnt == exp_cnt, "R5", "burst byte count", 32'(cnt), 32'(exp_cnt));
      if (bursts == 0) begin
        peek(3'd0, d);
        check(mem_addr == 16'((lba << 10)), "R11", "first word address",
              32'(mem_addr), 32'(16'((lba << 10))));
      end
      bus_read(3'd7, d);
      check(d == 16'h0048, "R5", "status before burst", 32'(d), 32'h0048);
      check(intrq == 1'b0, "R8", "status read clears irq", 32'(intrq), 32'd0);
      mism = 0;
      first_act = '0; first_exp = '0;
      for (int j = 0; j < exp_cnt / 2; j++) begin
        blk = lba + 32'(idx / 1024);
        w = 10'(idx % 1024);
        bus_read(3'd0, d);
        if (d != {blk[7:0], w[7:0]}) begin
          if (mism == 0) begin first_act = 32'(d); first_exp = 32'({blk[7:0], w[7:0]}); end
          mism++;
        end
        idx++;
      end
      check(mism == 0, "R6", "burst data words", first_act, first_exp);
      remaining -= exp_cnt;
      bursts++;
      if (remaining > 0) begin
        peek(3'd7, d);
        check(d == 16'h00C0 && intrq == 1'b0, "R10", "gap between bursts",
              32'({intrq, d}), 32'h00C0);
      end
    end
    wait_irq("R7");
    bus_read(3'd7, d);
    check(d == 16'h0040, "R7", "completion status", 32'(d), 32'h0040);
    check(bursts == exp_b, "R5", "burst count", 32'(bursts), 32'(exp_b));
  endtask

  task automatic expect_abort(input string req, input string what);
    logic [15:0] d;
    peek(3'd7, d);
    check(d == 16'h0041 && intrq == 1'b1, req, what, 32'({intrq, d}), 32'h0001_0041);
    bus_read(3'd7, d);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    // R1: reset state
    peek(3'd7, d);
    check(d == 16'h0040, "R1", "reset status", 32'(d), 32'h0040);
    check(intrq == 1'b0, "R1", "reset irq", 32'(intrq), 32'd0);
    peek(3'd0, d);
    check(d == 16'h0000, "R1", "reset data", 32'(d), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: stray data traffic while idle
    bus_write(3'd0, 16'hBEEF);
    bus_write(3'd0, 16'h1234);
    bus_write(3'd0, 16'h0028);
    bus_read(3'd0, d);
    check(d == 16'h0000, "R9", "idle data read", 32'(d), 32'd0);
    peek(3'd7, d);
    check(d == 16'h0040 && intrq == 1'b0, "R9", "idle unchanged", 32'({intrq, d}), 32'h0040);
    run_xfer(16'd5120, 32'h0000_0002, 16'd1, 1);  // R9: packet alignment intact

    // table of transfers
    for (int v = 0; v < 7; v++) begin
      run_xfer(VEC[v][79:64], VEC[v][63:32], VEC[v][31:16], int'(VEC[v][15:0]));
    end

    // R3: limit rejections and DMA request
    issue(16'd0, 8'd0);
    expect_abort("R3", "zero limit");
    issue(16'd1, 8'd0);
    expect_abort("R3", "limit one");
    issue(16'hFFFF, 8'd0);
    expect_abort("R3", "limit 0xFFFF");
    issue(16'd512, 8'd1);
    expect_abort("R3", "DMA requested");
    check(intrq == 1'b0, "R8", "irq cleared after abort", 32'(intrq), 32'd0);

    // R4: unknown packet opcode
    issue(16'd512, 8'd0);
    @(negedge clk);
    send_packet(8'h12, 32'd0, 16'd1);
    wait_irq("R4");
    expect_abort("R4", "bad opcode");

    // recovery after error
    run_xfer(16'd4096, 32'h0000_0010, 16'd2, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule